// File: doc/BRIEF.md
# DMA Peripheral Request Handler

This block sits between one DMA channel's instruction sequencer and a peripheral that asks that channel for transfers. The peripheral presents a request with a 2-bit type (single or burst) and a last flag. The block queues accepted requests in a small FIFO and confirms each acceptance on `req_ack`. The block also keeps the channel's current request type and last flag, which later commands consult.

The sequencer presents one decoded command per cycle on `cmd_op`. The wait-for-peripheral commands either stall the channel or pop the FIFO head, and they set the current flags from the popped entry. Flush empties the queue. Conditional transfer commands and the loop-end command ask whether they should run as a no-op. For a transfer command, the block also supplies the burst length to put on the bus. `stall`, `exec_nop` and `bus_len` are combinational answers to the command in the same cycle. All flag updates take effect at the next clock edge.

A burst is complete when a wait-for-burst command removes it or a flush discards it. The block signals this on `burst_done`. If a peripheral sends a single request while a burst is still outstanding, it breaks the protocol. The block records this in a sticky error flag.

Top module: `periph_req_tracker`

## Requirements
- R1: `req_ack` is high in a cycle if and only if all of these hold: `req_valid` is high, `req_type` is 2'b00 (single) or 2'b01 (burst), the FIFO holds fewer than DEPTH entries, and `cmd_op` is not flush. Type codes 2'b10 and 2'b11 are never accepted. An acknowledged request enters the FIFO at the next edge.
- R2: With DEPTH (default 4) entries queued, `req_ack` stays low even if an entry is popped in the same cycle. No queued entry is lost or overwritten.
- R3: The transfer-single command (`cmd_op` 3'd4) sets `exec_nop` when the current request type is burst. The transfer-burst command (3'd5) sets `exec_nop` when the current type is not burst.
- R4: The loop-end command (3'd6) sets `exec_nop` exactly when `cmd_nf` is 0 and the current last flag is 1.
- R5: For the transfer-single command, `bus_len` is 4'h0. For every other command, `bus_len` equals `cfg_len`.
- R6: The wait-single command (3'd1) has two cases. If the FIFO is empty, it raises `stall`. Otherwise it does not stall, and what happens depends on the head entry:
  - A single head is popped, and the current flags become single, with last taken from the entry.
  - A burst head stays queued, and the flags are unchanged.
- R7: The wait-burst command (3'd2) stalls unless the head entry is a burst. When the head is a burst, the command pops it, sets the current type to burst and copies the entry's last flag. `burst_done` is then high for the following cycle.
- R8: The flush command (3'd3) empties the FIFO and clears the current type to single and the last flag to 0. `burst_done` is then high for the following cycle.
- R9: `proto_err` becomes 1 after an edge where `req_valid` is high with type single while a burst entry is queued. It then stays 1 until reset.
- R10: After synchronous reset (`rst` high), the FIFO is empty, the current type is single, last is 0, and `proto_err` and `burst_done` are 0.
- R11: Entries leave the FIFO in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Peripheral request present |
| req_type | input | 2 | 2'b00 single, 2'b01 burst |
| req_last | input | 1 | Request is the last of its transfer |
| req_ack | output | 1 | Request accepted this cycle |
| cmd_op | input | 3 | 0 none, 1 wait-single, 2 wait-burst, 3 flush, 4 transfer-single, 5 transfer-burst, 6 loop-end |
| cmd_nf | input | 1 | nf bit of a loop-end command |
| cfg_len | input | LEN_W | Configured burst length |
| stall | output | 1 | Channel must hold the current command |
| exec_nop | output | 1 | Current command runs as a no-op |
| bus_len | output | LEN_W | Burst length for the bus |
| burst_done | output | 1 | Pulse: a burst was completed or flushed |
| proto_err | output | 1 | Sticky protocol violation |

## Verification
The bench goes after these corner cases:
- **Burst head under wait-single.** If a design pops this entry, later wait-burst commands stall forever. If it stalls instead, the channel hangs.
- **Full queue with a same-cycle pop.** A design that accepts here would overwrite an entry.
- **Flush with a concurrent request.** A design that accepts here would leave a stale entry behind the flush.
- **Loop-end with nf set.** A design that ignores nf would skip loop exits.
- **Single request behind a queued burst.** A design that misses this would leave `proto_err` clear. A design that does not hold the error would let it clear again.

The wrong length on a transfer-single command and entries returned out of order are also caught. The bench compares every output against a queue-based model every cycle, across directed sequences and a long random mix with periodic resets.

// File: rtl/preq_pkg.sv
package preq_pkg;
  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_WAIT_SINGLE = 3'd1,
    OP_WAIT_BURST  = 3'd2,
    OP_FLUSH       = 3'd3,
    OP_XFER_SINGLE = 3'd4,
    OP_XFER_BURST  = 3'd5,
    OP_LOOP_END    = 3'd6
  } cmd_op_e;

  localparam logic [1:0] RQ_SINGLE = 2'b00;
  localparam logic [1:0] RQ_BURST  = 2'b01;

  typedef struct packed {
    logic burst;
    logic last;
  } req_entry_t;
endpackage

// File: rtl/preq_fifo.sv
module preq_fifo
  import preq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       wr_en,
  input  req_entry_t wr_data,
  input  logic       rd_en,
  output req_entry_t head,
  output logic       empty,
  output logic       full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  req_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == FULL_CNT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full) else $error("write into full queue"); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty) else $error("pop from empty queue"); // R11
endmodule

// File: rtl/preq_cmd_eval.sv
module preq_cmd_eval
  import preq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  cmd_op_e          op,
  input  logic             nf,
  input  logic             q_empty,
  input  req_entry_t       q_head,
  input  logic             cur_burst,
  input  logic             cur_last,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             stall,
  output logic             exec_nop,
  output logic [LEN_W-1:0] bus_len,
  output logic             pop,
  output logic             flush
);
  always_comb begin
    stall    = 1'b0;
    exec_nop = 1'b0;
    bus_len  = cfg_len;
    pop      = 1'b0;
    flush    = 1'b0;
    case (op)
      OP_WAIT_SINGLE: begin
        if (q_empty)            stall = 1'b1;
        else if (!q_head.burst) pop   = 1'b1;
      end
      OP_WAIT_BURST: begin
        if (q_empty || !q_head.burst) stall = 1'b1;
        else                          pop   = 1'b1;
      end
      OP_FLUSH:       flush = 1'b1;
      OP_XFER_SINGLE: begin
        exec_nop = cur_burst;
        bus_len  = '0;
      end
      OP_XFER_BURST:  exec_nop = !cur_burst;
      OP_LOOP_END:    exec_nop = !nf && cur_last;
      default: ;
    endcase
  end
endmodule

// File: rtl/preq_state.sv
module preq_state
  import preq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       pop,
  input  req_entry_t head,
  input  logic       push_burst,
  input  logic       single_seen,
  output logic       cur_burst,
  output logic       cur_last,
  output logic       proto_err,
  output logic       burst_done
);
  localparam int BC_W = $clog2(DEPTH + 1);

  logic [BC_W-1:0] burst_cnt;
  logic            pop_burst;

  assign pop_burst = pop && head.burst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_burst  <= 1'b0;
      cur_last   <= 1'b0;
      proto_err  <= 1'b0;
      burst_done <= 1'b0;
      burst_cnt  <= '0;
    end else begin
      burst_done <= flush || pop_burst;
      if (single_seen && burst_cnt != '0) proto_err <= 1'b1;
      if (flush) begin
        cur_burst <= 1'b0;
        cur_last  <= 1'b0;
        burst_cnt <= '0;
      end else begin
        if (pop) begin
          cur_burst <= head.burst;
          cur_last  <= head.last;
        end
        burst_cnt <= burst_cnt + BC_W'(push_burst) - BC_W'(pop_burst);
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err) else $error("error flag dropped"); // R9
  AST_BURST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    burst_cnt <= BC_W'(DEPTH)) else $error("burst count out of range"); // R11
endmodule

// File: rtl/periph_req_tracker.sv
module periph_req_tracker
  import preq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_type,
  input  logic             req_last,
  output logic             req_ack,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_nf,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             stall,
  output logic             exec_nop,
  output logic [LEN_W-1:0] bus_len,
  output logic             burst_done,
  output logic             proto_err
);
  cmd_op_e    op;
  req_entry_t head, new_entry;
  logic       q_empty, q_full, pop, flush, cur_burst, cur_last, type_ok;

  assign op        = cmd_op_e'(cmd_op);
  assign type_ok   = (req_type == RQ_SINGLE) || (req_type == RQ_BURST);
  assign req_ack   = req_valid && type_ok && !q_full && !flush;
  assign new_entry = '{burst: (req_type == RQ_BURST), last: req_last};

  preq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(flush), .wr_en(req_ack), .wr_data(new_entry),
    .rd_en(pop), .head(head), .empty(q_empty), .full(q_full)
  );

  preq_cmd_eval #(.LEN_W(LEN_W)) u_eval (
    .op(op), .nf(cmd_nf), .q_empty(q_empty), .q_head(head),
    .cur_burst(cur_burst), .cur_last(cur_last), .cfg_len(cfg_len),
    .stall(stall), .exec_nop(exec_nop), .bus_len(bus_len), .pop(pop), .flush(flush)
  );

  preq_state #(.DEPTH(DEPTH)) u_state (
    .clk(clk), .rst(rst), .flush(flush), .pop(pop), .head(head),
    .push_burst(req_ack && new_entry.burst),
    .single_seen(req_valid && req_type == RQ_SINGLE),
    .cur_burst(cur_burst), .cur_last(cur_last),
    .proto_err(proto_err), .burst_done(burst_done)
  );

  AST_SINGLE_LEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd4) |-> (bus_len == '0)) else $error("single length"); // R5
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd3) |=> burst_done) else $error("flush without done"); // R8
  AST_LOOP_NF_RUNS: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd6 && cmd_nf) |-> !exec_nop) else $error("nf loop-end"); // R4
  AST_BAD_TYPE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_type[1]) |-> !req_ack) else $error("bad type accepted"); // R1
  AST_EMPTY_WAIT_STALLS: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'd2 && !$past(req_ack) && $past(cmd_op) == 3'd3) |-> stall)
    else $error("wait-burst after flush did not stall"); // R7
endmodule

// File: tb/periph_req_tracker_bench.sv
module periph_req_tracker_bench;
  import preq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int LEN_W = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_last = 0, cmd_nf = 0;
  logic [1:0] req_type = 0;
  logic [2:0] cmd_op = 0;
  logic [LEN_W-1:0] cfg_len = 0;
  logic req_ack, stall, exec_nop, burst_done, proto_err;
  logic [LEN_W-1:0] bus_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_req_tracker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_periph_req_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_last(req_last), .req_ack(req_ack), .cmd_op(cmd_op), .cmd_nf(cmd_nf),
    .cfg_len(cfg_len), .stall(stall), .exec_nop(exec_nop), .bus_len(bus_len),
    .burst_done(burst_done), .proto_err(proto_err)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [1:0] q[$];   // {burst,last}
  bit m_burst, m_last, m_err, m_done;

  task automatic chk(string tag, string note, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s t=%0t actual=%0d expected=%0d", tag, note, $time, act, exp);
    end
  endtask

  task automatic model_clear();
    q.delete(); m_burst = 0; m_last = 0; m_err = 0; m_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req_valid = 0; cmd_op = 0;
    repeat (2) @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 0;
  endtask

  task automatic step(bit v, bit [1:0] t, bit l, bit [2:0] op, bit nf, bit [3:0] len, string note);
    int sz; bit hb, any_b, e_ack, e_stall, e_nop; int e_len;
    @(negedge clk);
    req_valid = v; req_type = t; req_last = l; cmd_op = op; cmd_nf = nf; cfg_len = len;
    #1;
    sz = q.size();
    hb = (sz > 0) ? q[0][1] : 1'b0;
    e_ack = v && (t < 2) && (sz < DEPTH) && (op != 3'd3);
    e_stall = (op == 3'd1 && sz == 0) || (op == 3'd2 && (sz == 0 || !hb));
    e_nop = (op == 3'd4) ? m_burst : (op == 3'd5) ? !m_burst :
            (op == 3'd6) ? (!nf && m_last) : 1'b0;
    e_len = (op == 3'd4) ? 0 : len;
    vectors++;
    chk("R1/R2 req_ack", note, req_ack, e_ack);
    chk("R6/R7 stall", note, stall, e_stall);
    chk("R3/R4 exec_nop", note, exec_nop, e_nop);
    chk("R5 bus_len", note, bus_len, e_len);
    chk("R7/R8 burst_done", note, burst_done, m_done);
    chk("R9 proto_err", note, proto_err, m_err);
    @(posedge clk);
    any_b = 0;
    foreach (q[i]) if (q[i][1]) any_b = 1;
    if (v && t == 2'b00 && any_b) m_err = 1;
    if (op == 3'd3) begin
      q.delete(); m_burst = 0; m_last = 0; m_done = 1;
    end else begin
      m_done = 0;
      if (op == 3'd1 && sz > 0 && !hb) begin
        m_burst = 0; m_last = q[0][0]; void'(q.pop_front());
      end
      if (op == 3'd2 && sz > 0 && hb) begin
        m_burst = 1; m_last = q[0][0]; void'(q.pop_front()); m_done = 1;
      end
      if (e_ack) q.push_back({t[0], l});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    step(0, 0, 0, 3'd0, 0, 4'd5, "R10 idle");
    step(0, 0, 0, 3'd5, 0, 4'd5, "R10 type single after reset");
    step(0, 0, 0, 3'd4, 0, 4'd7, "R5 single length");
    step(0, 0, 0, 3'd1, 0, 4'd7, "R6 empty stall");
    // R1 accepts and R11 ordering
    step(1, 2'b00, 0, 3'd0, 0, 4'd3, "R1 single");
    step(1, 2'b00, 1, 3'd0, 0, 4'd3, "R1 single last");
    step(1, 2'b10, 0, 3'd0, 0, 4'd3, "R1 bad type");
    step(1, 2'b11, 1, 3'd0, 0, 4'd3, "R1 bad type");
    step(0, 0, 0, 3'd1, 0, 4'd3, "R11 first pop");
    step(0, 0, 0, 3'd6, 0, 4'd3, "R11 last=0 first");
    step(0, 0, 0, 3'd1, 0, 4'd3, "R11 second pop");
    step(0, 0, 0, 3'd6, 0, 4'd3, "R4 last set");
    step(0, 0, 0, 3'd6, 1, 4'd3, "R4 nf set");
    // burst handling
    step(1, 2'b01, 1, 3'd0, 0, 4'd9, "R1 burst");
    step(0, 0, 0, 3'd1, 0, 4'd9, "R6 burst head kept");
    step(0, 0, 0, 3'd1, 0, 4'd9, "R6 burst head kept again");
    step(0, 0, 0, 3'd5, 0, 4'd9, "R3 burst xfer as nop");
    step(0, 0, 0, 3'd2, 0, 4'd9, "R7 burst pop");
    step(0, 0, 0, 3'd5, 0, 4'd9, "R7 done pulse, R3 burst runs");
    step(0, 0, 0, 3'd4, 0, 4'd9, "R3 single xfer as nop");
    step(0, 0, 0, 3'd2, 0, 4'd9, "R7 empty stall");
    step(1, 2'b00, 0, 3'd2, 0, 4'd9, "R7 single head stall");
    step(0, 0, 0, 3'd2, 0, 4'd9, "R7 single head stall");
    // fill, full, flush
    for (int i = 0; i < 4; i++) step(1, 2'b00, i[0], 3'd0, 0, 4'd2, "R2 fill");
    step(1, 2'b00, 0, 3'd0, 0, 4'd2, "R2 full");
    step(1, 2'b00, 0, 3'd1, 0, 4'd2, "R2 full with pop");
    step(1, 2'b00, 0, 3'd3, 0, 4'd2, "R8 flush drops request");
    step(0, 0, 0, 3'd1, 0, 4'd2, "R8 done, empty");
    step(0, 0, 0, 3'd6, 0, 4'd2, "R8 last cleared");
    // protocol error
    step(1, 2'b01, 0, 3'd0, 0, 4'd1, "R9 burst");
    step(1, 2'b00, 0, 3'd0, 0, 4'd1, "R9 single behind burst");
    step(0, 0, 0, 3'd3, 0, 4'd1, "R9 error set");
    step(0, 0, 0, 3'd0, 0, 4'd1, "R9 error held");
    do_reset();
    step(0, 0, 0, 3'd0, 0, 4'd1, "R10 error cleared");
    // random mix
    for (int n = 0; n < 6000; n++) begin
      bit [1:0] t;
      if (n % 700 == 699) do_reset();
      t = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      step($urandom_range(0, 1), t, $urandom_range(0, 1), 3'($urandom_range(0, 6)),
           $urandom_range(0, 1), 4'($urandom_range(0, 15)), "random");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule